// File: doc/BRIEF.md
# CCD Row Transfer Clock Sequencer

This block produces the logic-level timing for moving one row of charge out of a full-frame CCD's imaging columns and into its serial register. It drives three vertical phase clocks, a transfer gate, and a request that freezes the horizontal clocks. A single-cycle start pulse begins one row transfer. The block then steps through a fixed list of edges, and a down-counter running on the system clock times the dwell before each next edge. When the list is finished the block raises a one-cycle done pulse.

Two orderings are available. Normal operation leaves phases 1 and 2 high while light is being integrated. Pinned-phase operation holds every vertical clock and the transfer gate low during integration, which suppresses surface dark current. The mode input is read at reset and when a start is accepted, and at no other time. Every vertical or gate edge occurs while the horizontal-freeze output is held high, so the serial clocks never move while a vertical edge happens. Charge crosses from the phase-3 electrode into the serial register while the transfer gate is high. The host decides how many rows to transfer by repeating the start.

Top module: `vxfer_seq`

## Requirements
- R1: While reset is held, and after it is released, busy and done are 0 and hhold is 0. In normal mode (mpp_mode=0) {v1,v2,v3,tg} is 1,1,0,0. In pinned-phase mode (mpp_mode=1) all four are 0.
- R2: A start seen while idle sets busy and hhold in the next cycle and leaves {v1,v2,v3,tg} unchanged in that cycle. The first vertical edge follows one dwell later. In both modes that edge gives v1=0, v2=1, v3=0, tg=1.
- R3: In normal mode the later edges come in this order: v3 rises, v2 falls, v1 rises, v3 falls, v2 rises, tg falls, and then hhold falls.
- R4: In normal mode, with default parameters, the edges occur 0, 26, 52, 78, 130, 144, 158, 204 and 230 cycles after the cycle in which hhold rose.
- R5: In pinned-phase mode the later edges come in this order: v3 rises, v2 falls, v1 rises, v3 falls, tg and v1 fall together, and then hhold falls.
- R6: In pinned-phase mode, with default parameters, the edges occur 0, 26, 78, 104, 130, 158, 204 and 230 cycles after the cycle in which hhold rose.
- R7: v1, v2, v3 and tg change only in a cycle where hhold was high in the previous cycle and is still high.
- R8: done is high for exactly one cycle, namely the cycle in which hhold falls. busy falls in that same cycle, and afterwards the outputs are at the idle levels of the mode that was run.
- R9: A start that arrives while busy is ignored. The running transfer keeps its timing, and no new transfer begins after it ends.
- R10: A change of mpp_mode while idle or busy has no effect on the outputs until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick is one dwell unit |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one row transfer (ignored while busy) |
| mpp_mode | input | 1 | 0 = normal ordering, 1 = pinned-phase ordering |
| v1 | output | 1 | Vertical phase 1 clock |
| v2 | output | 1 | Vertical phase 2 clock |
| v3 | output | 1 | Vertical phase 3 clock |
| tg | output | 1 | Transfer gate into the serial register |
| hhold | output | 1 | Freeze horizontal clocks (serial phase 1 held low) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The assertions check on every cycle that vertical and gate edges happen only while the horizontal freeze is in force, and that done is a single pulse coinciding with the release. They also check that an accepted start raises busy and the freeze at once, and that busy ends only with done. Which edge comes when, and in what order for each mode, can only be seen in the bench's complete transfers, which compare levels on both sides of every edge. The same applies to mode sampling across a change of mode between runs and to starts ignored in the middle of a transfer.

// File: rtl/vxfer_seq.sv
module vxfer_seq #(
  parameter int CW = 16,
  parameter int unsigned NRM_TICKS [8] = '{26, 26, 26, 52, 14, 14, 46, 26},
  parameter int unsigned MPP_TICKS [7] = '{26, 52, 26, 26, 28, 46, 26}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mpp_mode,
  output logic v1,
  output logic v2,
  output logic v3,
  output logic tg,
  output logic hhold,
  output logic busy,
  output logic done
);
  localparam logic [3:0] NRM_LAST = 4'd8;
  localparam logic [3:0] MPP_LAST = 4'd7;

  logic [CW-1:0] cnt_q;
  logic [3:0]    step_q;
  logic [3:0]    lv_q;
  logic          mode_q;
  logic          hold_q, busy_q, done_q;
  logic [3:0]    nxt;
  logic          at_end;

  // levels {v1,v2,v3,tg} resting between transfers
  function automatic logic [3:0] idle_lv(input logic m);
    return m ? 4'b0000 : 4'b1100;
  endfunction

  // levels {v1,v2,v3,tg} after edge number idx (1 .. last-1)
  function automatic logic [3:0] edge_lv(input logic m, input logic [3:0] idx);
    logic [3:0] r;
    r = idle_lv(m);
    if (!m) begin
      case (idx)
        4'd1: r = 4'b0101;
        4'd2: r = 4'b0111;
        4'd3: r = 4'b0011;
        4'd4: r = 4'b1011;
        4'd5: r = 4'b1001;
        4'd6: r = 4'b1101;
        4'd7: r = 4'b1100;
        default: r = 4'b1100;
      endcase
    end else begin
      case (idx)
        4'd1: r = 4'b0101;
        4'd2: r = 4'b0111;
        4'd3: r = 4'b0011;
        4'd4: r = 4'b1011;
        4'd5: r = 4'b1001;
        4'd6: r = 4'b0000;
        default: r = 4'b0000;
      endcase
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] dwell(input logic m, input logic [3:0] idx);
    int unsigned t;
    t = 1;
    if (!m) begin
      if (idx < NRM_LAST) t = NRM_TICKS[idx];
    end else begin
      if (idx < MPP_LAST) t = MPP_TICKS[idx];
    end
    return CW'(t - 1);
  endfunction

  assign nxt    = step_q + 4'd1;
  assign at_end = (nxt == (mode_q ? MPP_LAST : NRM_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mpp_mode;
      lv_q   <= idle_lv(mpp_mode);
      hold_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= 4'd0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          mode_q <= mpp_mode;
          busy_q <= 1'b1;
          hold_q <= 1'b1;
          step_q <= 4'd0;
          cnt_q  <= dwell(mpp_mode, 4'd0);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (at_end) begin
        hold_q <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
        step_q <= 4'd0;
      end else begin
        step_q <= nxt;
        lv_q   <= edge_lv(mode_q, nxt);
        cnt_q  <= dwell(mode_q, nxt);
      end
    end
  end

  assign {v1, v2, v3, tg} = lv_q;
  assign hhold = hold_q;
  assign busy  = busy_q;
  assign done  = done_q;
endmodule

// File: rtl/vxfer_seq_chk.sv
module vxfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mpp_mode,
  input logic v1,
  input logic v2,
  input logic v3,
  input logic tg,
  input logic hhold,
  input logic busy,
  input logic done
);
  // R7
  vert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({v1, v2, v3, tg}) |-> (hhold && $past(hhold)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !hhold && $past(hhold)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && hhold));

  // R9
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind vxfer_seq vxfer_seq_chk u_chk (.*);

// File: tb/sim_vxfer_seq.sv
`timescale 1ns/1ps
module sim_vxfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mpp_mode = 1'b0;
  logic v1, v2, v3, tg, hhold, busy, done;

  always #2.5 clk = ~clk;

  vxfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mpp_mode(mpp_mode),
    .v1(v1), .v2(v2), .v3(v3), .tg(tg),
    .hhold(hhold), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic       m;
    logic [8:0] t;
    logic [6:0] lv;
  } row_t;

  // lv = {hhold,v1,v2,v3,tg,busy,done}
  localparam row_t TBL [17] = '{
    '{1'b0, 9'd0,   7'b1110010},
    '{1'b0, 9'd26,  7'b1010110},
    '{1'b0, 9'd52,  7'b1011110},
    '{1'b0, 9'd78,  7'b1001110},
    '{1'b0, 9'd130, 7'b1101110},
    '{1'b0, 9'd144, 7'b1100110},
    '{1'b0, 9'd158, 7'b1110110},
    '{1'b0, 9'd204, 7'b1110010},
    '{1'b0, 9'd230, 7'b0110001},
    '{1'b1, 9'd0,   7'b1000010},
    '{1'b1, 9'd26,  7'b1010110},
    '{1'b1, 9'd78,  7'b1011110},
    '{1'b1, 9'd104, 7'b1001110},
    '{1'b1, 9'd130, 7'b1101110},
    '{1'b1, 9'd158, 7'b1100110},
    '{1'b1, 9'd204, 7'b1000010},
    '{1'b1, 9'd230, 7'b0000001}
  };
  localparam logic [6:0] IDLE_N = 7'b0110000;
  localparam logic [6:0] IDLE_M = 7'b0000000;

  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  bit finished = 0;

  function automatic logic [6:0] obs();
    return {hhold, v1, v2, v3, tg, busy, done};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s t=%0d got=%b exp=%b", req, cur_t, obs(), exp);
    end
  endtask

  task automatic goto(input int t);
    while (cur_t < t) begin
      @(negedge clk);
      cur_t++;
    end
  endtask

  task automatic do_reset(input logic m);
    mpp_mode = m;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", m ? IDLE_M : IDLE_N);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", m ? IDLE_M : IDLE_N);
  endtask

  task automatic launch(input logic m);
    mpp_mode = m;
    start = 1'b1;
    cur_t = -1;
    goto(0);
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] prev;
    string tag;
    prev = IDLE_N;
    for (int i = 0; i < 17; i++) begin
      tag = TBL[i].m ? "R5 R6" : "R3 R4";
      if (TBL[i].t == 9'd0) begin
        do_reset(TBL[i].m);
        prev = TBL[i].m ? IDLE_M : IDLE_N;
        launch(TBL[i].m);
        chk("R2", TBL[i].lv);
      end else begin
        goto(int'(TBL[i].t) - 1);
        chk(tag, prev);
        goto(int'(TBL[i].t));
        chk(tag, TBL[i].lv);
      end
      prev = TBL[i].lv;
      if (TBL[i].lv[0]) begin
        goto(int'(TBL[i].t) + 1);
        chk("R8", TBL[i].m ? IDLE_M : IDLE_N);
      end
    end

    // R10: mode change while idle (last run was pinned-phase)
    mpp_mode = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 idle", IDLE_M);

    // R2: normal run started from pinned-phase idle
    launch(1'b0);
    chk("R2 cross", 7'b1000010);
    goto(26);
    chk("R2 cross", 7'b1010110);
    goto(51);
    chk("R3 cross", 7'b1010110);
    goto(52);
    chk("R3 cross", 7'b1011110);
    goto(60);
    mpp_mode = 1'b1;
    goto(77);
    chk("R10 busy", 7'b1011110);
    goto(78);
    chk("R10 busy", 7'b1001110);
    goto(100);
    start = 1'b1;
    goto(101);
    start = 1'b0;
    goto(129);
    chk("R9", 7'b1001110);
    goto(130);
    chk("R9", 7'b1101110);
    goto(229);
    chk("R9", 7'b1110010);
    goto(230);
    chk("R8", 7'b0110001);
    goto(231);
    chk("R8", IDLE_N);
    goto(240);
    chk("R9 no restart", IDLE_N);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule